// File: doc/BRIEF.md
# Bidirectional Cascaded Column Data Register

This block collects one display line of pixel data for a single column driver that sits in a chain with other drivers. Each driver owns a slice of 128 pixels, which is 384 six-bit subpixel slots. A driver stays idle until an enable token arrives on one of its two chain pins. It then takes exactly 128 pixels, one in each cycle where the pixel is valid, and places the red, green and blue parts of each pixel into consecutive slots. While it takes the last pixel it passes a one-cycle token out on its other chain pin, so the next driver in the chain continues with no gap.

A direction strap controls two things. It sets which chain pin listens and which one drives, and it sets whether the buffer fills from the lowest output upward or from the highest output downward. Colours always keep their positions: red lands on output numbers that are 1 modulo 3, green on those that are 2 modulo 3, and blue on multiples of 3.

A rising edge on the load input copies the whole line buffer into a holding latch. That latch feeds the conversion stage, and it stays unchanged while the next line fills.

Top module: `column_data_register`

## Requirements
- R1: After synchronous active-low reset, every holding slot reads zero and neither chain pin drives a token.
- R2: With `dir_up` high, chain pin A is the input (`chain_a_oe`=0) and chain pin B is the output (`chain_b_oe`=1). With `dir_up` low the two roles swap.
- R3: With `dir_up` high, the k-th pixel after a token (k from 0) goes to outputs 3k+1, 3k+2 and 3k+3 as red, green and blue. Output n (1-based) occupies `hold_out[(n-1)*6 +: 6]`.
- R4: With `dir_up` low, the k-th pixel goes to outputs 382-3k, 383-3k and 384-3k as red, green and blue.
- R5: A token on the pin that is currently the output has no effect. Pixels sent after it are not stored.
- R6: After a token the block stores exactly 128 pixels. Valid pixels that arrive with no pending token, or after the 128th pixel, are ignored.
- R7: In the cycle that the 128th pixel is accepted, the output-role pin is high for exactly one cycle. The input-role pin never drives.
- R8: Cycles with `pix_valid` low during a fill store nothing and do not advance the slot position.
- R9: The holding latch takes the line buffer only at a rising edge of `load`. It takes the contents as they were before any write in that same cycle. A `load` held high does not copy again.
- R10: A token that stays high for two cycles starts only one fill. A token that arrives during a fill does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_up | input | 1 | Direction strap: 1 fills upward, 0 fills downward |
| chain_a_in | input | 1 | Chain pin A, input value |
| chain_a_out | output | 1 | Chain pin A, driven token value |
| chain_a_oe | output | 1 | Chain pin A output enable |
| chain_b_in | input | 1 | Chain pin B, input value |
| chain_b_out | output | 1 | Chain pin B, driven token value |
| chain_b_oe | output | 1 | Chain pin B output enable |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_r | input | 6 | Red subpixel |
| pix_g | input | 6 | Green subpixel |
| pix_b | input | 6 | Blue subpixel |
| load | input | 1 | Line transfer strobe; acts on its rising edge |
| hold_out | output | 2304 | Holding latch, 384 slots of 6 bits, output 1 in the lowest bits |

## Verification
The hardest cases to reach are the ones where a token shows up while the block is already filling, or a token stays high for a second cycle. In both, a block that restarts would overwrite the early slots, and nothing changes at the pins until the next load. The stimulus therefore sends a two-cycle token in the downward direction and a second token halfway through the pixel stream. It then sends surplus pixels and loads the line. Finally it checks the first and last pixel slots against the order computed from the direction rule. A `load` is also held high across the start of a new fill, to show that the latch keeps the previous line.

// File: rtl/cdr_pkg.sv
// Shared definitions for the column data register.
// Assumes three colour lanes per pixel.
package cdr_pkg;
    localparam int COLORS = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/cdr_chain_port.sv
// Chain pin steering. Selects which chain pin listens for the enable token
// and which one drives the outgoing token, based on the direction strap.
// Assumes the strap is static while a fill is in progress.
module cdr_chain_port (
    input  logic dir_up,
    input  logic a_in,
    input  logic b_in,
    input  logic tok_out,
    output logic a_out,
    output logic a_oe,
    output logic b_out,
    output logic b_oe,
    output logic tok_in
);
    // Pin roles: upward fill listens on A and drives B, downward is the mirror.
    always_comb begin
        a_oe   = ~dir_up;
        b_oe   = dir_up;
        a_out  = tok_out & ~dir_up;
        b_out  = tok_out & dir_up;
        tok_in = dir_up ? a_in : b_in;
    end
endmodule

// File: rtl/cdr_fill_ctrl.sv
// Token-driven fill sequencer. Waits for an input token, accepts exactly
// PIXELS valid pixels, produces the pixel slot index for the chosen
// direction, and flags the last accepted pixel as the outgoing token.
// Assumes tokens are short pulses; any token seen while filling is ignored.
module cdr_fill_ctrl
    import cdr_pkg::*;
#(
    parameter int PIXELS = 128,
    localparam int IW = $clog2(PIXELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_up,
    input  logic          tok_in,
    input  logic          pix_valid,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic          tok_out
);
    localparam logic [IW-1:0] LAST = IW'(PIXELS - 1);

    fill_state_e   state;
    logic [IW-1:0] cnt;

    // Sequencer: idle until a token, then count accepted pixels up to LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (tok_in) state <= ST_FILL;
                end
                default: begin
                    if (pix_valid) begin
                        if (cnt == LAST) begin
                            state <= ST_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Write strobe, direction-mapped pixel index and outgoing token.
    always_comb begin
        wr_en   = (state == ST_FILL) && pix_valid;
        wr_idx  = dir_up ? cnt : (LAST - cnt);
        tok_out = wr_en && (cnt == LAST);
    end

    // A fill ends right after the token is passed on.
    assert_token_ends_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> (state == ST_IDLE));

    // Idle cycles inside a fill keep the position.
    assert_gap_holds_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && !pix_valid) |=> ($stable(cnt) && state == ST_FILL));

    // Every fill begins at the first pixel.
    assert_fill_starts_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tok_in) |=> (cnt == '0));

    // A fill never jumps back to the start before its last pixel.
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && cnt != LAST) |=> (state == ST_FILL));
endmodule

// File: rtl/cdr_line_store.sv
// Line buffer and holding latch. Each pixel position holds {blue,green,red}
// so that red sits at the lowest output of the triple. A rising edge on
// load copies the whole buffer into the holding latch.
// Assumes wr_idx is below PIXELS whenever wr_en is high.
module cdr_line_store
    import cdr_pkg::*;
#(
    parameter int PIXELS = 128,
    parameter int DW     = 6,
    localparam int IW    = $clog2(PIXELS),
    localparam int PW    = COLORS * DW,
    localparam int LW    = PIXELS * PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] pix_r,
    input  logic [DW-1:0] pix_g,
    input  logic [DW-1:0] pix_b,
    input  logic          load,
    output logic [LW-1:0] hold_q
);
    logic [LW-1:0] line_flat;
    logic          load_q;
    logic          load_rise;
    logic [PW-1:0] pix_word;

    assign pix_word  = {pix_b, pix_g, pix_r};
    assign load_rise = load & ~load_q;

    for (genvar i = 0; i < PIXELS; i++) begin : g_pix
        // One pixel position of the line buffer, written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_flat[i*PW +: PW] <= '0;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                line_flat[i*PW +: PW] <= pix_word;
            end
        end
    end

    // Holding latch and load edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= load;
            if (load_rise) hold_q <= line_flat;
        end
    end

    // The latch takes the buffer as it stood before the edge.
    assert_hold_copies_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_rise |=> (hold_q == $past(line_flat)));

    // Without a load edge the latch keeps its value.
    assert_hold_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_rise |=> $stable(hold_q));
endmodule

// File: rtl/column_data_register.sv
// Top of the cascaded column data register for one driver in a chain.
// Joins pin steering, the fill sequencer and the line store.
// Assumes the direction strap does not change during a fill.
module column_data_register
    import cdr_pkg::*;
#(
    parameter int PIXELS = 128,
    parameter int DW     = 6,
    localparam int IW    = $clog2(PIXELS),
    localparam int SLOTS = PIXELS * COLORS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_up,
    input  logic               chain_a_in,
    output logic               chain_a_out,
    output logic               chain_a_oe,
    input  logic               chain_b_in,
    output logic               chain_b_out,
    output logic               chain_b_oe,
    input  logic               pix_valid,
    input  logic [DW-1:0]      pix_r,
    input  logic [DW-1:0]      pix_g,
    input  logic [DW-1:0]      pix_b,
    input  logic               load,
    output logic [SLOTS*DW-1:0] hold_out
);
    logic          tok_in;
    logic          tok_out;
    logic          wr_en;
    logic [IW-1:0] wr_idx;

    cdr_chain_port u_port (
        .dir_up  (dir_up),
        .a_in    (chain_a_in),
        .b_in    (chain_b_in),
        .tok_out (tok_out),
        .a_out   (chain_a_out),
        .a_oe    (chain_a_oe),
        .b_out   (chain_b_out),
        .b_oe    (chain_b_oe),
        .tok_in  (tok_in)
    );

    cdr_fill_ctrl #(.PIXELS(PIXELS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_up    (dir_up),
        .tok_in    (tok_in),
        .pix_valid (pix_valid),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .tok_out   (tok_out)
    );

    cdr_line_store #(.PIXELS(PIXELS), .DW(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .pix_r  (pix_r),
        .pix_g  (pix_g),
        .pix_b  (pix_b),
        .load   (load),
        .hold_q (hold_out)
    );

    // Outgoing tokens are single-cycle pulses on either pin.
    assert_single_pulse_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_b_out |=> !chain_b_out);
    assert_single_pulse_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_a_out |=> !chain_a_out);
endmodule

// File: tb/column_data_register_test.sv
`timescale 1ns/100ps
module column_data_register_test;
    localparam int P  = 128;
    localparam int NS = P * 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_up = 1'b1;
    logic a_in = 1'b0, b_in = 1'b0;
    logic a_out, a_oe, b_out, b_oe;
    logic pix_valid = 1'b0;
    logic [5:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic load = 1'b0;
    logic [NS*6-1:0] hold_out;

    int checks = 0;
    int fails = 0;
    int a_pulses = 0;
    int b_pulses = 0;
    bit started = 0;
    bit done = 0;

    // Behavioural reference state
    logic [5:0] line_m[NS];
    logic [5:0] hold_m[NS];
    bit filling_m = 0;
    int cnt_m = 0;
    bit load_prev_m = 0;

    always #2 clk = ~clk;

    column_data_register uut (
        .clk(clk), .rst_n(rst_n), .dir_up(dir_up),
        .chain_a_in(a_in), .chain_a_out(a_out), .chain_a_oe(a_oe),
        .chain_b_in(b_in), .chain_b_out(b_out), .chain_b_oe(b_oe),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .load(load), .hold_out(hold_out)
    );

    function automatic logic [5:0] pv(int k, int c, int seed);
        return 6'((k * 5 + c * 17 + seed) & 63);
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int slot(int s);
        return int'(hold_out[s*6 +: 6]);
    endfunction

    // Reference model update on every rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin line_m[s] = '0; hold_m[s] = '0; end
            filling_m = 0; cnt_m = 0; load_prev_m = 0;
        end else begin
            if (load && !load_prev_m)
                for (int s = 0; s < NS; s++) hold_m[s] = line_m[s];
            load_prev_m = load;
            if (!filling_m) begin
                if (dir_up ? a_in : b_in) begin filling_m = 1; cnt_m = 0; end
            end else if (pix_valid) begin
                int base;
                base = dir_up ? 3 * cnt_m : 3 * (P - 1 - cnt_m);
                line_m[base] = pix_r; line_m[base+1] = pix_g; line_m[base+2] = pix_b;
                if (cnt_m == P - 1) begin filling_m = 0; cnt_m = 0; end
                else cnt_m++;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            bit tok;
            int bad;
            tok = filling_m && pix_valid && (cnt_m == P - 1);
            check("R2 a_oe", a_oe, !dir_up);
            check("R2 b_oe", b_oe, dir_up);
            check("R7 a_out", a_out, tok && !dir_up);
            check("R7 b_out", b_out, tok && dir_up);
            bad = -1;
            for (int s = 0; s < NS; s++)
                if (bad < 0 && hold_out[s*6 +: 6] !== hold_m[s]) bad = s;
            checks++;
            if (bad >= 0) begin
                fails++;
                $display("FAIL R9 model slot %0d actual=%0d expected=%0d",
                         bad, hold_out[bad*6 +: 6], hold_m[bad]);
            end
            if (a_out) a_pulses++;
            if (b_out) b_pulses++;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 0; a_in = 0; b_in = 0;
        end
    endtask

    task automatic token(bit on_a, int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            pix_valid = 0;
            a_in = on_a; b_in = !on_a;
        end
        @(negedge clk);
        a_in = 0; b_in = 0;
    endtask

    task automatic pixels(int first, int n, int seed, bit gaps);
        for (int k = first; k < first + n; k++) begin
            if (gaps && (k % 3 == 1)) begin
                @(negedge clk);
                pix_valid = 0; a_in = 0; b_in = 0;
                pix_r = 6'h3f; pix_g = 6'h3f; pix_b = 6'h3f;
            end
            @(negedge clk);
            a_in = 0; b_in = 0;
            pix_valid = 1;
            pix_r = pv(k, 0, seed); pix_g = pv(k, 1, seed); pix_b = pv(k, 2, seed);
        end
        @(negedge clk);
        pix_valid = 0;
    endtask

    task automatic pulse_load(int len);
        idle(6);
        for (int i = 0; i < len; i++) begin @(negedge clk); load = 1; end
        @(negedge clk); load = 0;
        idle(3);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        #1;
        // R1: reset state
        check("R1 slot0", slot(0), 0);
        check("R1 slot383", slot(383), 0);
        check("R1 chain outs", a_out | b_out, 0);
        check("R2 up roles", {a_oe, b_oe}, 2'b01);

        // R3: upward fill, R7: single token out on B
        a_pulses = 0; b_pulses = 0;
        token(1, 1);
        pixels(0, P, 1, 0);
        check("R7 b pulses", b_pulses, 1);
        check("R7 a silent", a_pulses, 0);
        pulse_load(5);
        check("R3 slot0 red", slot(0), pv(0, 0, 1));
        check("R3 slot1 green", slot(1), pv(0, 1, 1));
        check("R3 slot151 green", slot(151), pv(50, 1, 1));
        check("R3 slot383 blue", slot(383), pv(127, 2, 1));

        // R6: pixels with no token are ignored
        pixels(0, 10, 9, 0);
        pulse_load(5);
        check("R6 no token slot0", slot(0), pv(0, 0, 1));

        // R5: token on the output-role pin does nothing
        token(0, 1);
        pixels(0, 10, 20, 0);
        pulse_load(5);
        check("R5 wrong pin slot0", slot(0), pv(0, 0, 1));
        check("R5 wrong pin slot29", slot(29), pv(9, 2, 1));

        // R4, R8, R10: downward fill, 2-cycle token, gaps, mid-fill token
        @(negedge clk); dir_up = 0;
        #1;
        check("R2 down roles", {a_oe, b_oe}, 2'b10);
        a_pulses = 0; b_pulses = 0;
        token(0, 2);
        pixels(0, 64, 33, 1);
        token(0, 1);
        pixels(64, 64, 33, 1);
        pixels(0, 5, 40, 0);
        check("R7 a pulses down", a_pulses, 1);
        check("R7 b silent down", b_pulses, 0);
        pulse_load(5);
        check("R4 slot381 red", slot(381), pv(0, 0, 33));
        check("R4 slot383 blue", slot(383), pv(0, 2, 33));
        check("R10 slot0 red", slot(0), pv(127, 0, 33));
        check("R8 slot2 blue", slot(2), pv(127, 2, 33));
        check("R6 surplus ignored slot3", slot(3), pv(126, 0, 33));

        // R9: load held high while a new fill starts copies only once
        @(negedge clk); dir_up = 1; load = 1;
        token(1, 1);
        pixels(0, 20, 50, 0);
        @(negedge clk); load = 0;
        check("R9 held load slot0", slot(0), pv(127, 0, 33));
        pixels(20, P - 20, 50, 0);
        pulse_load(5);
        check("R9 new line slot0", slot(0), pv(0, 0, 50));
        check("R9 new line slot383", slot(383), pv(127, 2, 50));

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule